// File: doc/BRIEF.md
# Serial and Parallel I/Q Sample Output Formatter

This block sits at the output of a receive datapath. Each cycle it may be handed one complex sample (an I word and a Q word) with a valid strobe. It then presents the sample in one of two ways. In parallel mode both words appear on wide output buses. In serial mode the words are shifted out one bit at a time on data lines, together with a generated bit clock.

Control ports, sampled as plain inputs, choose the following:
- the bit period, which is 1, 2, 4 or 8 master clocks;
- whether I and Q are sent side by side on two lines, or one after the other on a single line;
- whether the most or the least significant bit goes first;
- whether the numeric format is two's complement or offset binary;
- the active level of the data-ready flag;
- which edge the bit clock makes in the middle of each bit.

When a serial transfer starts, the block takes a snapshot of its settings and keeps it until the last bit has gone. A sample that arrives while a serial word is still being sent is discarded, and a sticky overrun flag records the loss. The last cycle of a transfer is the exception: a sample arriving then is accepted, so transfers can follow one another with no gap.

Top module: `sample_out_fmt`

## Requirements
- R1: With `cfg_serial`=0, an accepted sample appears on `par_i`/`par_q` in the cycle after the edge that sampled `in_valid`. It then holds until the next accepted parallel sample.
- R2: With `cfg_serial`=1, bit k of a transfer is presented during clocks k·P to k·P+P−1 after the accepting edge, where P = 2^`cfg_div` (codes 0,1,2,3 give P = 1,2,4,8).
- R3: `ser_clk` stays high throughout when the bit period is one clock. Otherwise, with `cfg_clk_inv`=0, it is low in the first half of each bit and high in the second half, and `cfg_clk_inv`=1 inverts it. When idle it rests at 1 for code 0 and at `cfg_clk_inv` for other codes.
- R4: With `cfg_seq`=0, a transfer is W bits long, with I on `ser_i` and Q on `ser_q` at the same time. When idle, both lines are 0.
- R5: With `cfg_seq`=1, a transfer is 2W bits long on `ser_i`: the whole I word, then the whole Q word. `ser_q` stays 0.
- R6: `cfg_msb_first`=1 sends bit W−1 of each word first; 0 sends bit 0 first.
- R7: `cfg_offset`=1 inverts the sign bit (bit W−1) of both words, in both modes. 0 passes two's complement unchanged.
- R8: The data-ready flag is raw-active during the whole first bit period of each serial word (at the start of I, and at the start of Q in sequential mode). In parallel mode it is raw-active for exactly the one cycle in which a new word appears. `data_rdy` equals that raw value XOR `cfg_rdy_low`, so `cfg_rdy_low`=1 makes it active low.
- R9: Mode, order, format, bit period and clock phase are captured at acceptance. Changing them during a transfer does not alter that transfer.
- R10: A valid sample arriving while a serial transfer is busy (other than in its final cycle) is dropped: no output changes because of it, and `overrun` goes to 1 and stays there until reset.
- R11: A valid sample arriving in the final cycle of a transfer is accepted. Its first bit follows at once, with no idle cycle between transfers.
- R12: After synchronous reset the block is idle: `par_i`/`par_q` = 0, `overrun` = 0, serial lines 0 and `data_rdy` inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | W | In-phase word, two's complement |
| in_q | input | W | Quadrature word, two's complement |
| cfg_serial | input | 1 | 1 = serial output, 0 = parallel output |
| cfg_div | input | 2 | Bit period code, P = 2^code clocks |
| cfg_seq | input | 1 | 1 = I word then Q word, 0 = I and Q together |
| cfg_msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| cfg_offset | input | 1 | 1 = offset binary, 0 = two's complement |
| cfg_rdy_low | input | 1 | 1 = data-ready active low |
| cfg_clk_inv | input | 1 | 1 = falling bit clock edge at mid-bit |
| ser_clk | output | 1 | Serial bit clock |
| ser_i | output | 1 | Serial I data (and Q in sequential mode) |
| ser_q | output | 1 | Serial Q data |
| par_i | output | W | Parallel I word |
| par_q | output | W | Parallel Q word |
| data_rdy | output | 1 | Data-ready flag |
| overrun | output | 1 | Sticky dropped-sample flag |

## Verification
All outputs change one register stage after the edge that samples `in_valid`. The parallel word, its ready pulse and the overrun flag are therefore due in the very next cycle, and the first serial bit appears at the same time. Every later serial bit, and its bit-clock half, is due a fixed P clocks after the one before. The bench has a behavioural model that advances on each rising edge from the same inputs the design sees. It compares every output at the following falling edge, so each result is checked in the exact cycle it is due, never a cycle late or early.

// File: rtl/sof_pkg.sv
package sof_pkg;

    typedef enum logic {
        OM_PARALLEL = 1'b0,
        OM_SERIAL   = 1'b1
    } out_mode_e;

    // settings frozen for the life of one serial transfer
    typedef struct packed {
        logic       seq;
        logic       clk_inv;
        logic [1:0] div;
    } xfer_cfg_t;

    // last phase index inside one bit period
    function automatic logic [2:0] period_max(input logic [1:0] d);
        return 3'((4'd1 << d) - 4'd1);
    endfunction

    // first phase index of the second half of a bit period
    function automatic logic [2:0] half_phase(input logic [1:0] d);
        return (d == 2'd0) ? 3'd0 : 3'(4'd1 << (d - 2'd1));
    endfunction

endpackage

// File: rtl/sof_fmt.sv
module sof_fmt #(
    parameter int W = 16
) (
    input  logic [W-1:0] word_in,
    input  logic         offset,
    output logic [W-1:0] word_out
);
    // offset binary differs from two's complement only in the sign bit
    assign word_out = {word_in[W-1] ^ offset, word_in[W-2:0]};
endmodule

// File: rtl/sof_bit_timer.sv
module sof_bit_timer
    import sof_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = $clog2(2 * W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    div,
    input  logic [BW-1:0] nbits,
    output logic          busy,
    output logic [BW-1:0] bit_idx,
    output logic          bit_end,
    output logic          done,
    output logic          clk_lvl
);
    logic [2:0]    ph;
    logic [1:0]    div_q;
    logic [BW-1:0] nb_q;
    logic [2:0]    ph_last;

    assign ph_last = period_max(div_q);
    assign bit_end = busy && (ph == ph_last);
    assign done    = bit_end && (bit_idx == nb_q - BW'(1));
    assign clk_lvl = (div_q != 2'd0) && (ph >= half_phase(div_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            ph      <= '0;
            bit_idx <= '0;
            div_q   <= '0;
            nb_q    <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            ph      <= '0;
            bit_idx <= '0;
            div_q   <= div;
            nb_q    <= nbits;
        end else if (busy) begin
            if (ph == ph_last) begin
                ph <= '0;
                if (done) busy <= 1'b0;
                else      bit_idx <= bit_idx + BW'(1);
            end else begin
                ph <= ph + 3'd1;
            end
        end
    end

    // a bit index never runs past the word length of its transfer
    p_bit_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_idx < nb_q));

    // the presented bit stays put for a whole bit period
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_end && !start) |=> (busy && $stable(bit_idx)));
endmodule

// File: rtl/sof_shifter.sv
module sof_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic         msb_first,
    input  logic         seq,
    input  logic [W-1:0] word_i,
    input  logic [W-1:0] word_q,
    output logic         bit_i,
    output logic         bit_q
);
    logic [2*W-1:0] sr;
    logic [W-1:0]   sq;
    logic           msb_q;
    logic [W-1:0]   tail;

    assign tail  = seq ? word_q : '0;
    assign bit_i = msb_q ? sr[2*W-1] : sr[0];
    assign bit_q = msb_q ? sq[W-1]   : sq[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            sq    <= '0;
            msb_q <= 1'b1;
        end else if (load) begin
            msb_q <= msb_first;
            sq    <= word_q;
            sr    <= msb_first ? {word_i, tail} : {tail, word_i};
        end else if (adv) begin
            sr <= msb_q ? (sr << 1) : (sr >> 1);
            sq <= msb_q ? (sq << 1) : (sq >> 1);
        end
    end

    // between bit boundaries the shift contents are frozen
    p_shift_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> ($stable(sr) && $stable(sq)));
endmodule

// File: rtl/sample_out_fmt.sv
module sample_out_fmt
    import sof_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_i,
    input  logic [W-1:0] in_q,
    input  logic         cfg_serial,
    input  logic [1:0]   cfg_div,
    input  logic         cfg_seq,
    input  logic         cfg_msb_first,
    input  logic         cfg_offset,
    input  logic         cfg_rdy_low,
    input  logic         cfg_clk_inv,
    output logic         ser_clk,
    output logic         ser_i,
    output logic         ser_q,
    output logic [W-1:0] par_i,
    output logic [W-1:0] par_q,
    output logic         data_rdy,
    output logic         overrun
);
    localparam int BW = $clog2(2 * W + 1);

    out_mode_e     mode;
    xfer_cfg_t     cap;
    logic [W-1:0]  fmt_i, fmt_q;
    logic          busy, bit_end, done, clk_lvl;
    logic [BW-1:0] bit_idx, nbits;
    logic          accept, start_ser, load_par;
    logic          sh_i, sh_q, first_bit;
    logic          par_pulse;

    assign mode      = out_mode_e'(cfg_serial);
    assign accept    = in_valid && (!busy || done);
    assign start_ser = accept && (mode == OM_SERIAL);
    assign load_par  = accept && (mode == OM_PARALLEL);
    assign nbits     = cfg_seq ? BW'(2 * W) : BW'(W);

    sof_fmt #(.W(W)) u_fmt_i (.word_in(in_i), .offset(cfg_offset), .word_out(fmt_i));
    sof_fmt #(.W(W)) u_fmt_q (.word_in(in_q), .offset(cfg_offset), .word_out(fmt_q));

    sof_bit_timer #(.W(W), .BW(BW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start_ser),
        .div     (cfg_div),
        .nbits   (nbits),
        .busy    (busy),
        .bit_idx (bit_idx),
        .bit_end (bit_end),
        .done    (done),
        .clk_lvl (clk_lvl)
    );

    sof_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (start_ser),
        .adv       (bit_end && !done),
        .msb_first (cfg_msb_first),
        .seq       (cfg_seq),
        .word_i    (fmt_i),
        .word_q    (fmt_q),
        .bit_i     (sh_i),
        .bit_q     (sh_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap       <= '0;
            par_i     <= '0;
            par_q     <= '0;
            par_pulse <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            par_pulse <= load_par;
            if (start_ser) begin
                cap.seq     <= cfg_seq;
                cap.clk_inv <= cfg_clk_inv;
                cap.div     <= cfg_div;
            end
            if (load_par) begin
                par_i <= fmt_i;
                par_q <= fmt_q;
            end
            if (in_valid && !accept) overrun <= 1'b1;
        end
    end

    assign first_bit = busy && ((bit_idx == '0) || (cap.seq && (bit_idx == BW'(W))));
    assign data_rdy  = (first_bit | par_pulse) ^ cfg_rdy_low;
    assign ser_i     = busy && sh_i;
    assign ser_q     = busy && !cap.seq && sh_q;

    always_comb begin
        if (busy)
            ser_clk = (cap.div == 2'd0) ? 1'b1 : (clk_lvl ^ cap.clk_inv);
        else
            ser_clk = (cfg_div == 2'd0) ? 1'b1 : cfg_clk_inv;
    end

    // once a sample has been lost the flag stays up
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // a parallel ready pulse never overlaps a serial transfer
    p_no_dual_ready_r8: assert property (@(posedge clk) disable iff (rst)
        !(busy && par_pulse));

    // parallel words move only together with their ready pulse
    p_par_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !par_pulse |-> ($stable(par_i) && $stable(par_q)));

    // in sequential mode the quadrature line stays quiet
    p_seq_q_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && cap.seq) |-> !ser_q);
endmodule

// File: tb/sim_sample_out_fmt.sv
module sim_sample_out_fmt;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [W-1:0] in_i = '0, in_q = '0;
    logic cfg_serial = 1'b0, cfg_seq = 1'b0, cfg_msb_first = 1'b1;
    logic cfg_offset = 1'b0, cfg_rdy_low = 1'b0, cfg_clk_inv = 1'b0;
    logic [1:0] cfg_div = 2'd0;
    logic ser_clk, ser_i, ser_q, data_rdy, overrun;
    logic [W-1:0] par_i, par_q;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sample_out_fmt #(.W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cfg_serial(cfg_serial), .cfg_div(cfg_div), .cfg_seq(cfg_seq),
        .cfg_msb_first(cfg_msb_first), .cfg_offset(cfg_offset),
        .cfg_rdy_low(cfg_rdy_low), .cfg_clk_inv(cfg_clk_inv),
        .ser_clk(ser_clk), .ser_i(ser_i), .ser_q(ser_q),
        .par_i(par_i), .par_q(par_q), .data_rdy(data_rdy), .overrun(overrun)
    );

    // behavioural reference state
    bit m_busy = 0, m_seq = 0, m_msb = 0, m_inv = 0, m_pulse = 0, m_ovr = 0;
    int m_per = 1, m_ph = 0, m_bit = 0, m_len = 0, m_div = 0;
    logic [W-1:0] m_wi = '0, m_wq = '0, m_pi = '0, m_pq = '0;

    function automatic logic [W-1:0] conv(input logic [W-1:0] v, input logic off);
        logic [W-1:0] r;
        r = v;
        if (off) r[W-1] = ~r[W-1];
        return r;
    endfunction

    task automatic model_edge();
        bit fin, acc;
        if (rst) begin
            m_busy = 0; m_pulse = 0; m_ovr = 0; m_pi = '0; m_pq = '0;
            return;
        end
        fin = m_busy && (m_ph == m_per - 1) && (m_bit == m_len - 1);
        acc = in_valid && (!m_busy || fin);
        if (in_valid && !acc) m_ovr = 1;
        m_pulse = 0;
        if (m_busy) begin
            if (m_ph == m_per - 1) begin
                m_ph = 0;
                if (fin) m_busy = 0; else m_bit++;
            end else m_ph++;
        end
        if (acc) begin
            if (cfg_serial) begin
                m_busy = 1; m_ph = 0; m_bit = 0;
                m_div = int'(cfg_div); m_per = 1 << m_div;
                m_seq = cfg_seq; m_msb = cfg_msb_first; m_inv = cfg_clk_inv;
                m_len = cfg_seq ? 2 * W : W;
                m_wi = conv(in_i, cfg_offset); m_wq = conv(in_q, cfg_offset);
            end else begin
                m_pi = conv(in_i, cfg_offset); m_pq = conv(in_q, cfg_offset);
                m_pulse = 1;
            end
        end
    endtask

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        int k, pos;
        logic [W-1:0] w;
        logic e_clk, e_i, e_q, e_rdy;
        if (!m_busy) begin
            e_clk = (cfg_div == 2'd0) ? 1'b1 : cfg_clk_inv;
            e_i = 0; e_q = 0;
        end else begin
            e_clk = (m_per == 1) ? 1'b1 : (((m_ph >= m_per / 2) ? 1'b1 : 1'b0) ^ m_inv);
            k   = m_seq ? (m_bit % W) : m_bit;
            pos = m_msb ? (W - 1 - k) : k;
            w   = (m_seq && m_bit >= W) ? m_wq : m_wi;
            e_i = w[pos];
            e_q = m_seq ? 1'b0 : m_wq[pos];
        end
        e_rdy = ((m_busy && (m_bit == 0 || (m_seq && m_bit == W))) || m_pulse) ^ cfg_rdy_low;
        chk("R2 R3 ser_clk", W'(ser_clk), W'(e_clk));
        chk("R2 R4 R5 R6 R7 R9 R11 ser_i", W'(ser_i), W'(e_i));
        chk("R4 R5 R6 R9 ser_q", W'(ser_q), W'(e_q));
        chk("R1 R7 R10 par_i", par_i, m_pi);
        chk("R1 R7 R10 par_q", par_q, m_pq);
        chk("R8 data_rdy", W'(data_rdy), W'(e_rdy));
        chk("R10 overrun", W'(overrun), W'(m_ovr));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) step();
    endtask

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b);
        in_valid = 1; in_i = a; in_q = b;
        step();
        in_valid = 0;
    endtask

    initial begin
        idle(3);
        // R12: reset state at the ports
        chk("R12 par_i", par_i, '0);
        chk("R12 overrun", W'(overrun), '0);
        chk("R12 data_rdy", W'(data_rdy), '0);
        chk("R12 ser_i", W'(ser_i), '0);
        rst = 0;
        idle(2);

        // R1 R7 R8: parallel words, formats and polarity
        send(16'h1234, 16'h8001); idle(2);
        cfg_offset = 1; send(16'h7FFF, 16'h8000); idle(1);
        cfg_rdy_low = 1; send(16'h0F0F, 16'hF0F0);
        send(16'hAAAA, 16'h5555); idle(2);
        cfg_offset = 0; cfg_rdy_low = 0;

        // R2 R3 R4 R5 R6 R8: every serial configuration
        for (int d = 0; d < 4; d++)
            for (int s = 0; s < 2; s++)
                for (int m = 0; m < 2; m++) begin
                    cfg_serial = 1; cfg_div = 2'(d); cfg_seq = s[0]; cfg_msb_first = m[0];
                    cfg_clk_inv = d[0] ^ m[0]; cfg_rdy_low = s[0] ^ m[0]; cfg_offset = d[1];
                    send(16'hA5C3 ^ 16'(d * 16'h1357 + s * 16'h0F1E + m * 16'h3003),
                         16'h3C96 ^ 16'(d * 16'h2468 + m * 16'h4111));
                    idle((s + 1) * W * (1 << d) + 3);
                end

        // R9: settings change in the middle of a transfer
        cfg_div = 2'd1; cfg_seq = 0; cfg_msb_first = 1; cfg_offset = 0; cfg_clk_inv = 0;
        send(16'h9C41, 16'h2B7E);
        idle(5);
        cfg_msb_first = 0; cfg_seq = 1; cfg_offset = 1; cfg_clk_inv = 1; cfg_div = 2'd3;
        idle(2 * W + 4);

        // R10: a sample during a busy transfer is dropped and flagged
        cfg_div = 2'd1; cfg_seq = 0; cfg_msb_first = 1; cfg_offset = 0; cfg_clk_inv = 0;
        send(16'h1111, 16'h2222);
        idle(4);
        send(16'hFFFF, 16'hFFFF);
        cfg_serial = 0; send(16'h7777, 16'h6666);
        cfg_serial = 1;
        idle(2 * W + 2);
        chk("R10 sticky overrun", W'(overrun), W'(1));

        // R11: back-to-back serial transfers at one clock per bit
        cfg_div = 2'd0;
        send(16'hC3A5, 16'h5A3C);
        idle(W - 1);
        send(16'h0123, 16'hFEDC);
        idle(W - 1);
        cfg_serial = 0; send(16'h4321, 16'h8765);
        idle(3);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule